// File: doc/BRIEF.md
# Memory Protection Execute-Permission Checker

This block judges every instruction fetch and data access on a processor address path against a protection configuration. The configuration has a control word and a small bank of programmable regions, each with a base, a power-of-two size, an access-permission code and an execute-never bit. A fixed physical address map sits under the programmed regions. Some address ranges are physically device-type, so nothing can ever be fetched from them. A programmed region can add restrictions on top of that map, but it cannot make a device range executable.

Each access is presented for one cycle with its address, its kind (read, write or fetch), its privilege and whether it comes from a high-priority fault handler. One cycle later the block returns a valid strobe, a fault flag and a cause code. Configuration writes come through a three-register interface: control, base/region-select and attribute. A write and an access in the same cycle are legal. In that case the access is judged against the configuration as it stood before the write.

Top module: `mpx_guard`

## Requirements
- R1: After a synchronous reset, the control word is 0, every region is disabled and the region select is 0. While reset is held, res_valid, res_fault and res_cause are all 0.
- R2: The result for an access on acc_valid appears on the following cycle with res_valid=1. A cycle without acc_valid gives res_valid=0, res_fault=0 and res_cause=0 on the next cycle. res_fault is 1 exactly when res_cause is not 0.
- R3: Protection is off when control bit 0 is 0. The fixed map then decides alone. A fetch (acc_kind=2) from 0x40000000–0x5FFFFFFF or from 0xA0000000–0xFFFFFFFF faults with cause 4. Every other access is allowed. Kind 0 is read, kind 1 is write, and kind 3 is treated as a read.
- R4: Writes use cfg_addr 0 for control (bits 2:0), 1 for base and 2 for attribute. A write with cfg_addr 3 has no effect. In a base write with bit 4 set, bits 2:0 choose the region and become the new selection (bit 3 is ignored). With bit 4 clear, the currently selected region is written. Bits 31:5 always give the base. An attribute write goes to the selected region: bit 0 enable, bits 5:1 SIZE, bits 26:24 access permission, bit 28 XN. All other attribute bits are ignored.
- R5: A region spans 2^(SIZE+1) bytes. SIZE values below 4 act as 4 (32 bytes), and SIZE 31 covers all 4 GB. Base bits below the region size are ignored when matching.
- R6: When several enabled regions match, only the highest-numbered one decides.
- R7: With protection on and no region matching, the access faults with cause 1. The exception is control bit 2 set with a privileged access: the fixed map of R3 then decides.
- R8: Access-permission codes work as follows. Code 0 and code 4 deny everything. Code 1 allows privileged read and write. Code 2 allows privileged read and write plus unprivileged read. Code 3 allows read and write at both levels. Code 5 allows privileged read only. Codes 6 and 7 allow read only at both levels. A fetch needs read permission. A denial faults with cause 2.
- R9: A fetch that hits a region with XN=1 faults with cause 3. Reads and writes never produce cause 3 or 4.
- R10: A fetch in a device range of R3 faults with cause 4, even when the winning region has XN=0 and full access.
- R11: When several causes apply to a region hit, they are reported in this order: permission (2), then region XN (3), then device XN (4).
- R12: During a high-priority handler access (acc_hipri=1), protection applies only if control bit 1 is set. Otherwise the fixed map of R3 decides.
- R13: An access presented in the same cycle as a configuration write is judged with the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register: 0 control, 1 base, 2 attribute, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_priv | input | 1 | Access is privileged |
| acc_hipri | input | 1 | Access comes from a high-priority fault handler |
| res_valid | output | 1 | Result valid, one cycle after acc_valid |
| res_fault | output | 1 | Access faults |
| res_cause | output | 3 | 0 allowed, 1 no hit, 2 permission, 3 region XN, 4 device XN |

## Verification
A configuration write and an access can fall in the same cycle. The bench provokes this by turning protection on and off in the very cycle it presents an access to a range no region covers. The result must follow the old control word, and the access in the next cycle must follow the new one. A behavioural model in the bench applies its own copy of each write only after it has computed the expected result for the access in that cycle. Every cycle is compared against that model. This also covers overlapping regions, the cause priorities, size clamping and the device-range rule.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 5;
    localparam int BASE_W   = ADDR_W - BASE_LSB;
    localparam int MIN_SIZE = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_NO_HIT    = 3'd1,
        CAUSE_PERM      = 3'd2,
        CAUSE_REGION_XN = 3'd3,
        CAUSE_DEVICE_XN = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        CFG_CTRL = 2'd0,
        CFG_BASE = 2'd1,
        CFG_ATTR = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    // Field order matches control bits 2:0
    typedef struct packed {
        logic privdef;
        logic hipri_keep;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [4:0]        size;
        logic [2:0]        ap;
        logic              xn;
        logic              en;
    } region_t;

    // Bits that take part in the address compare for a given size code
    function automatic logic [ADDR_W-1:0] region_mask(input logic [4:0] size);
        logic [4:0]        eff;
        logic [ADDR_W-1:0] m;
        eff = (size < 5'(MIN_SIZE)) ? 5'(MIN_SIZE) : size;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i > int'(eff));
        end
        return m;
    endfunction

    // Physically device-type ranges: never executable
    function automatic logic is_device(input logic [ADDR_W-1:0] a);
        return (a[31:29] == 3'b010) || (a >= 32'hA000_0000);
    endfunction

    function automatic logic ap_read_ok(input logic [2:0] ap, input logic priv);
        case (ap)
            3'd1, 3'd5: return priv;
            3'd2, 3'd3, 3'd6, 3'd7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ap_write_ok(input logic [2:0] ap, input logic priv);
        case (ap)
            3'd1, 3'd2: return priv;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mpx_cfg_regs.sv
module mpx_cfg_regs
    import mpx_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output ctrl_t                 ctrl,
    output region_t [NREG-1:0]    regions
);
    localparam int SEL_W = $clog2(NREG);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] base_tgt;
    cfg_sel_e         which;

    assign which    = cfg_sel_e'(cfg_addr);
    assign base_tgt = cfg_wdata[4] ? cfg_wdata[SEL_W-1:0] : sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            sel_q   <= '0;
            regions <= '0;
        end else if (cfg_we) begin
            case (which)
                CFG_CTRL: ctrl <= ctrl_t'(cfg_wdata[2:0]);
                CFG_BASE: begin
                    if (cfg_wdata[4]) sel_q <= cfg_wdata[SEL_W-1:0];
                    regions[base_tgt].base <= cfg_wdata[31:BASE_LSB];
                end
                CFG_ATTR: begin
                    regions[sel_q].en   <= cfg_wdata[0];
                    regions[sel_q].size <= cfg_wdata[5:1];
                    regions[sel_q].ap   <= cfg_wdata[26:24];
                    regions[sel_q].xn   <= cfg_wdata[28];
                end
                default: ;
            endcase
        end
    end

    assert_attr_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && which == CFG_ATTR) |=> (regions[$past(sel_q)].en == $past(cfg_wdata[0])));

    assert_none_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && which == CFG_NONE) |=> ($stable(ctrl) && $stable(sel_q)));

endmodule

// File: rtl/mpx_region_hit.sv
module mpx_region_hit
    import mpx_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    input  region_t [NREG-1:0]    regions,
    output logic                  any_hit,
    output logic [2:0]            win_ap,
    output logic                  win_xn
);
    localparam int SEL_W = $clog2(NREG);

    logic [NREG-1:0]  hit;
    logic [SEL_W-1:0] win_idx;

    for (genvar g = 0; g < NREG; g++) begin : g_match
        logic [ADDR_W-1:0] base_full;
        assign base_full = {regions[g].base, {BASE_LSB{1'b0}}};
        assign hit[g] = regions[g].en &&
                        (((addr ^ base_full) & region_mask(regions[g].size)) == '0);
    end

    // Highest-numbered matching region wins
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                win_idx = SEL_W'(i);
            end
        end
    end

    assign win_ap = regions[win_idx].ap;
    assign win_xn = regions[win_idx].xn;

endmodule

// File: rtl/mpx_verdict.sv
module mpx_verdict
    import mpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_priv,
    input  logic              acc_hipri,
    input  logic              any_hit,
    input  logic [2:0]        win_ap,
    input  logic              win_xn,
    output logic              res_valid,
    output logic              res_fault,
    output logic [2:0]        res_cause
);
    acc_kind_e kind;
    cause_e    map_cause;
    cause_e    cause;
    logic      prot_on;
    logic      is_fetch;
    logic      is_write;
    logic      dev;
    logic      perm_ok;

    assign kind     = acc_kind_e'(acc_kind);
    assign is_fetch = (kind == ACC_FETCH);
    assign is_write = (kind == ACC_WRITE);
    assign dev      = is_device(acc_addr);
    assign prot_on  = ctrl.enable && (!acc_hipri || ctrl.hipri_keep);
    assign perm_ok  = is_write ? ap_write_ok(win_ap, acc_priv) : ap_read_ok(win_ap, acc_priv);

    always_comb begin
        map_cause = (is_fetch && dev) ? CAUSE_DEVICE_XN : CAUSE_NONE;
        if (!prot_on) begin
            cause = map_cause;
        end else if (!any_hit) begin
            cause = (ctrl.privdef && acc_priv) ? map_cause : CAUSE_NO_HIT;
        end else if (!perm_ok) begin
            cause = CAUSE_PERM;
        end else if (is_fetch && win_xn) begin
            cause = CAUSE_REGION_XN;
        end else if (is_fetch && dev) begin
            cause = CAUSE_DEVICE_XN;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_cause <= CAUSE_NONE;
        end else begin
            res_valid <= acc_valid;
            res_fault <= acc_valid && (cause != CAUSE_NONE);
            res_cause <= acc_valid ? cause : CAUSE_NONE;
        end
    end

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!res_valid && !res_fault && res_cause == 3'd0));

    assert_xn_fetch_only_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !is_fetch) |=> (res_cause != 3'd3 && res_cause != 3'd4));

    assert_device_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && is_fetch && dev) |=> res_fault);

    assert_prot_off_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !ctrl.enable && !is_fetch) |=> !res_fault);

    assert_no_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && prot_on && !any_hit && !(ctrl.privdef && acc_priv)) |=> (res_cause == 3'd1));

endmodule

// File: rtl/mpx_guard.sv
module mpx_guard
    import mpx_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_kind,
    input  logic        acc_priv,
    input  logic        acc_hipri,
    output logic        res_valid,
    output logic        res_fault,
    output logic [2:0]  res_cause
);
    ctrl_t              ctrl;
    region_t [NREG-1:0] regions;
    logic               any_hit;
    logic [2:0]         win_ap;
    logic               win_xn;

    mpx_cfg_regs #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .regions   (regions)
    );

    mpx_region_hit #(.NREG(NREG)) u_hit (
        .addr    (acc_addr),
        .regions (regions),
        .any_hit (any_hit),
        .win_ap  (win_ap),
        .win_xn  (win_xn)
    );

    mpx_verdict u_verdict (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_kind  (acc_kind),
        .acc_priv  (acc_priv),
        .acc_hipri (acc_hipri),
        .any_hit   (any_hit),
        .win_ap    (win_ap),
        .win_xn    (win_xn),
        .res_valid (res_valid),
        .res_fault (res_fault),
        .res_cause (res_cause)
    );

    assert_fault_matches_cause_R2: assert property (@(posedge clk) disable iff (rst)
        res_fault == (res_cause != 3'd0));

endmodule

// File: tb/mpx_guard_test.sv
module mpx_guard_test;

    localparam int RD = 0;
    localparam int WR = 1;
    localparam int FX = 2;
    localparam logic [1:0] C_CTRL = 2'd0;
    localparam logic [1:0] C_BASE = 2'd1;
    localparam logic [1:0] C_ATTR = 2'd2;
    localparam logic [1:0] C_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0;
    logic        acc_hipri = 1'b0;
    logic        res_valid;
    logic        res_fault;
    logic [2:0]  res_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int unsigned m_base [8];
    int          m_size [8];
    int          m_ap   [8];
    bit          m_xn   [8];
    bit          m_en   [8];
    int          m_ctrl;
    int          m_sel;

    always #10 clk = ~clk;

    mpx_guard uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_hipri(acc_hipri),
        .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause)
    );

    function automatic void model_reset();
        for (int r = 0; r < 8; r++) begin
            m_base[r] = 0; m_size[r] = 0; m_ap[r] = 0; m_xn[r] = 0; m_en[r] = 0;
        end
        m_ctrl = 0;
        m_sel  = 0;
    endfunction

    function automatic void model_write(input logic [1:0] ca, input logic [31:0] wd);
        if (ca == C_CTRL) m_ctrl = int'(wd[2:0]);
        else if (ca == C_BASE) begin
            if (wd[4]) m_sel = int'(wd[2:0]);
            m_base[m_sel] = wd & 32'hFFFF_FFE0;
        end else if (ca == C_ATTR) begin
            m_en[m_sel]   = wd[0];
            m_size[m_sel] = int'(wd[5:1]);
            m_ap[m_sel]   = int'(wd[26:24]);
            m_xn[m_sel]   = wd[28];
        end
    endfunction

    function automatic int model_cause(input logic [31:0] a, input int k, input bit pv, input bit hp);
        bit dev;
        int dflt;
        int w;
        bit ok;
        bit on;
        longint sz, lo, aa;
        aa   = longint'(a);
        dev  = (aa >= 64'h4000_0000 && aa <= 64'h5FFF_FFFF) || aa >= 64'hA000_0000;
        dflt = (k == FX && dev) ? 4 : 0;
        on   = m_ctrl[0] && (!hp || m_ctrl[1]);
        if (!on) return dflt;
        w = -1;
        for (int r = 0; r < 8; r++) begin
            if (m_en[r]) begin
                sz = 64'd1 << (((m_size[r] < 4) ? 4 : m_size[r]) + 1);
                lo = longint'(m_base[r]) - (longint'(m_base[r]) % sz);
                if (aa >= lo && aa < lo + sz) w = r;
            end
        end
        if (w < 0) return (m_ctrl[2] && pv) ? dflt : 1;
        if (k == WR) ok = (m_ap[w] == 3) || (pv && (m_ap[w] == 1 || m_ap[w] == 2));
        else ok = (m_ap[w] == 2 || m_ap[w] == 3 || m_ap[w] == 6 || m_ap[w] == 7) ||
                  (pv && (m_ap[w] == 1 || m_ap[w] == 5));
        if (!ok) return 2;
        if (k == FX && m_xn[w]) return 3;
        if (k == FX && dev) return 4;
        return 0;
    endfunction

    task automatic check(input string rq, input bit ev, input int ec);
        checks++;
        if (res_valid !== ev || res_cause !== 3'(ec) || res_fault !== (ec != 0)) begin
            errors++;
            $display("FAIL %s: valid/fault/cause actual %0b/%0b/%0d expected %0b/%0b/%0d",
                     rq, res_valid, res_fault, res_cause, ev, (ec != 0), ec);
        end
    endtask

    // one cycle: drive at falling edge, compare at the next falling edge
    task automatic step(input bit we, input logic [1:0] ca, input logic [31:0] wd,
                        input bit av, input logic [31:0] aa, input int k,
                        input bit pv, input bit hp, input string rq);
        int ec;
        cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
        acc_valid = av; acc_addr = aa; acc_kind = 2'(k); acc_priv = pv; acc_hipri = hp;
        ec = av ? model_cause(aa, k, pv, hp) : 0;
        if (we) model_write(ca, wd);
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check(rq, av, ec);
    endtask

    task automatic cfg(input logic [1:0] ca, input logic [31:0] wd, input string rq);
        step(1'b1, ca, wd, 1'b0, 32'h0, RD, 1'b0, 1'b0, rq);
    endtask

    task automatic acc(input logic [31:0] aa, input int k, input bit pv, input bit hp, input string rq);
        step(1'b0, C_NONE, 32'h0, 1'b1, aa, k, pv, hp, rq);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        check("R1", 1'b0, 0);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // fixed map with protection off
        acc(32'h0000_1000, FX, 1, 0, "R3");
        acc(32'hF000_0000, FX, 1, 0, "R3");
        acc(32'hF000_0000, RD, 0, 0, "R3");
        acc(32'h4000_0000, FX, 1, 0, "R3");
        acc(32'h9FFF_FFFC, FX, 0, 0, "R3");
        acc(32'h6000_0000, FX, 0, 0, "R3");
        step(1'b0, C_NONE, 32'h0, 1'b0, 32'hF000_0000, FX, 1, 0, "R2");

        // region 0: whole space, full access, executable
        cfg(C_BASE, 32'h0000_0010, "R4");
        cfg(C_ATTR, 32'h0307_003F, "R4");
        cfg(C_CTRL, 32'h0000_0001, "R4");
        acc(32'hF000_0000, FX, 1, 0, "R10");
        acc(32'hE010_0000, FX, 0, 0, "R10");
        acc(32'h0000_0000, FX, 0, 0, "R10");
        acc(32'hF000_0000, WR, 0, 0, "R9");

        // region 1: 4 KB, XN
        cfg(C_BASE, 32'h2000_0011, "R4");
        cfg(C_ATTR, 32'h1300_0017, "R4");
        acc(32'h2000_0010, FX, 1, 0, "R6 R9");
        acc(32'h2000_1000, FX, 1, 0, "R5");
        acc(32'h2000_0010, RD, 0, 0, "R9");

        // region 2: 32 bytes, privileged only, executable
        cfg(C_BASE, 32'h2000_0012, "R4");
        cfg(C_ATTR, 32'h0100_0009, "R4");
        acc(32'h2000_0004, RD, 0, 0, "R8");
        acc(32'h2000_0004, RD, 1, 0, "R8");
        acc(32'h2000_0004, FX, 1, 0, "R6");
        acc(32'h2000_0004, WR, 0, 0, "R8");
        acc(32'h2000_0020, FX, 1, 0, "R5");

        // region 4: device range, privileged read-only, XN
        cfg(C_BASE, 32'hA000_0014, "R4");
        cfg(C_ATTR, 32'h1500_0009, "R4");
        acc(32'hA000_0000, FX, 0, 0, "R11");
        acc(32'hA000_0000, FX, 1, 0, "R11");
        acc(32'hA000_0000, WR, 1, 0, "R8");
        acc(32'hA000_0000, RD, 1, 0, "R8");

        // region 3: misaligned base, 512 bytes; disable region 0
        cfg(C_BASE, 32'h3000_0113, "R4");
        cfg(C_ATTR, 32'h0300_0011, "R4");
        cfg(C_BASE, 32'h0000_0010, "R4");
        cfg(C_ATTR, 32'h0000_0000, "R4");
        acc(32'h3000_01FC, RD, 0, 0, "R5");
        acc(32'h3000_0000, RD, 0, 0, "R5");
        acc(32'h3000_0200, RD, 0, 0, "R7");

        // region 5: size code 0 acts as 32 bytes
        cfg(C_BASE, 32'h6000_0015, "R4");
        cfg(C_ATTR, 32'h0300_0001, "R4");
        acc(32'h6000_001C, RD, 0, 0, "R5");
        acc(32'h6000_0020, RD, 0, 0, "R5");

        // base write without the select flag moves the selected region
        cfg(C_BASE, 32'h7000_0000, "R4");
        acc(32'h7000_0004, RD, 0, 0, "R4");
        acc(32'h6000_0004, RD, 0, 0, "R4");

        // unused slot has no effect
        cfg(C_NONE, 32'hFFFF_FFFF, "R4");
        acc(32'h7000_0004, WR, 0, 0, "R4");
        acc(32'h5000_0000, RD, 1, 0, "R4");

        // privileged default map
        cfg(C_CTRL, 32'h0000_0005, "R7");
        acc(32'h5000_0000, RD, 1, 0, "R7");
        acc(32'h5000_0000, FX, 1, 0, "R7");
        acc(32'h5000_0000, RD, 0, 0, "R7");
        acc(32'h1000_0000, FX, 1, 0, "R7");

        // high-priority handler bypass
        cfg(C_CTRL, 32'h0000_0001, "R12");
        acc(32'h5000_0000, RD, 0, 1, "R12");
        acc(32'h5000_0000, FX, 0, 1, "R12");
        acc(32'h5000_0000, RD, 0, 0, "R12");
        cfg(C_CTRL, 32'h0000_0003, "R12");
        acc(32'h5000_0000, RD, 0, 1, "R12");

        // configuration write and access in the same cycle
        step(1'b1, C_CTRL, 32'h0, 1'b1, 32'h5000_0000, RD, 0, 0, "R13");
        acc(32'h5000_0000, RD, 0, 0, "R13");
        step(1'b1, C_CTRL, 32'h3, 1'b1, 32'h5000_0000, RD, 0, 0, "R13");
        acc(32'h5000_0000, RD, 0, 0, "R13");
        step(1'b1, C_ATTR, 32'h0, 1'b1, 32'h7000_0004, RD, 0, 0, "R13");
        acc(32'h7000_0004, RD, 0, 0, "R13");

        // protection off ignores region XN
        cfg(C_CTRL, 32'h0, "R3");
        acc(32'h2000_0010, FX, 0, 0, "R3");
        acc(32'h2000_0010, 3, 0, 0, "R3");

        // reset clears regions; region number bit 3 ignored
        do_reset();
        cfg(C_CTRL, 32'h0000_0001, "R1");
        acc(32'h2000_0000, RD, 1, 0, "R1");
        cfg(C_BASE, 32'h0000_001F, "R4");
        cfg(C_ATTR, 32'h0307_003F, "R4");
        acc(32'h0000_0100, FX, 0, 0, "R4");
        acc(32'h8000_0000, WR, 0, 0, "R4");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule